// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold Window Comparator

This block is the digital controller for a successive-approximation converter core with a 12-bit result. A trigger starts a pass over the enabled inputs of a 16-way analog multiplexer. The trigger can be a software write, a rising edge on an external pin, a timer output or a PWM event line.

For each enabled input, the controller:

- drives the multiplexer select;
- waits a programmable tracking interval;
- pulses the converter start;
- captures the returned sample.

An optional sleep mode keeps the core powered down while idle and inserts a programmable wake-up delay before the first conversion.

Every captured sample goes to a per-channel result register and to a shared last-result register. A one-cycle strobe marks each update for a DMA requester. Each sample is also tested against a low/high threshold pair in one of four window modes. A match sets a sticky flag that drives the fault output without any further register stage. Software reads the flag to clear it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Address 2 bits [NCH-1:0] enable channels; one trigger converts every enabled channel exactly once in ascending channel order, and with no channel enabled a trigger starts nothing.
- R2: Mode register (address 1) bits [1:0] pick the trigger: 0 = software (a write to address 0 with bit 0 set), 1 = external pin, 2 = timer line, 3 = PWM event line; hardware sources act on a rising edge, and unselected sources (including software writes when a hardware source is picked) are ignored.
- R3: Triggers arriving while a pass is running (busy high) are ignored and do not add conversions.
- R4: Mode bit 2 = 0 stores the full sample; mode bit 2 = 1 stores only the 10 most significant bits, right-aligned with zero fill.
- R5: Each sample is stored in the channel register at address 16+channel, bits [DW-1:0], and in the last-result register at address 5 with the value in bits [DW-1:0] and the channel number in bits [16+CH_W-1:16].
- R6: With sleep off and mode bits [15:12] = T, conv_start is a one-cycle pulse seen T+1 cycles after the trigger edge. mux_sel holds the channel number while the conversion is outstanding.
- R7: Mode bit 3 enables sleep, and core_pwr is then low whenever the block is idle (core_pwr is high out of reset, when sleep is off). With mode bits [11:4] = S, the first conv_start comes S+T+2 cycles after the trigger edge.
- R8: Address 3 bits [1:0] set the compare mode against thresholds at address 4 (low in bits [DW-1:0], high in bits [16+DW-1:16]), applied to the stored value v: 0 = v below low, 1 = v above high, 2 = low <= v <= high, 3 = v below low or above high.
- R9: Address 3 bit 2 = 1 compares every channel; otherwise only the channel in bits [8+CH_W-1:8] is compared.
- R10: fault equals a sticky match flag that is set by a matching store. The flag is returned in bit 0 of address 8 and holds until that address is read, and the read clears it.
- R11: Address 6 returns one end-of-conversion bit per channel. A store sets the bit, and a read of that channel's result register clears it.
- R12: Address 7 returns one overrun bit per channel. A bit is set when a store hits a channel whose end-of-conversion bit is still set, and a read of address 7 clears all of them.
- R13: drdy is a one-cycle strobe in the cycle after each store, once per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (applies read side effects) |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ext_trig | input | 1 | External trigger pin |
| tmr_trig | input | 1 | Timer output trigger |
| pwm_trig | input | 1 | PWM event line trigger |
| mux_sel | output | CH_W | Analog multiplexer channel select |
| core_pwr | output | 1 | Converter core power enable |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_done | input | 1 | Core result valid pulse |
| conv_data | input | DW | Core result |
| busy | output | 1 | A pass is in progress |
| drdy | output | 1 | Last-result update strobe for DMA |
| fault | output | 1 | Window match fault output |

## Verification
The sequencer is driven with enable masks that have a single low bit, a single high bit, a sparse alternating pattern, all bits and none. Together these separate ordering faults, off-by-one scan limits and spurious starts on an empty mask. Tracking and wake-up delays are swept over zero and non-zero values, which pins the start pulse to the exact cycle and catches a missing or extra counter stage. Each trigger source is exercised against the others, and a trigger is repeated during a pass. The comparator is swept over all four modes with samples below, on and above each threshold, which catches inclusive/exclusive mistakes at the window edges. Single-channel and all-channel selection are also tried, to check that the compare-channel field is obeyed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WAKE, ST_TRACK, ST_START, ST_WAIT
   } seq_state_e;

   typedef enum logic [1:0] {
      TRG_SOFT, TRG_PIN, TRG_TIMER, TRG_PWM
   } trig_src_e;

   typedef enum logic [1:0] {
      CMP_BELOW, CMP_ABOVE, CMP_INSIDE, CMP_OUTSIDE
   } cmp_mode_e;

   localparam logic [5:0] A_CTRL   = 6'd0;
   localparam logic [5:0] A_MODE   = 6'd1;
   localparam logic [5:0] A_CHEN   = 6'd2;
   localparam logic [5:0] A_CMPCFG = 6'd3;
   localparam logic [5:0] A_THR    = 6'd4;
   localparam logic [5:0] A_LAST   = 6'd5;
   localparam logic [5:0] A_EOC    = 6'd6;
   localparam logic [5:0] A_OVR    = 6'd7;
   localparam logic [5:0] A_CMPST  = 6'd8;
   localparam logic [5:0] A_CHBASE = 6'd16;

   // lowest set bit of mask at or above 'from'; result = {found, index}
   function automatic logic [5:0] scan_up(input logic [31:0] mask, input logic [5:0] from);
      logic [5:0] r;
      r = '0;
      for (int i = 31; i >= 0; i--) begin
         if (mask[i] && (6'(i) >= from)) r = {1'b1, 5'(i)};
      end
      return r;
   endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
   import adc_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  trig_src_e src,
   input  logic      sw_go,
   input  logic      ext_in,
   input  logic      tmr_in,
   input  logic      pwm_in,
   output logic      go
);
   logic [2:0] raw;
   logic [2:0] prev_q;
   logic [2:0] rise;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("adc_trig_sel: SYNC_STAGES must be >= 0");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign raw = {pwm_in, tmr_in, ext_in};
   end else begin : g_sync
      logic [2:0] sh_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sh_q[i] <= '0;
         end else begin
            sh_q[0] <= {pwm_in, tmr_in, ext_in};
            for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
         end
      end
      assign raw = sh_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= raw;
   end

   assign rise = raw & ~prev_q;

   always_comb begin
      unique case (src)
         TRG_SOFT:  go = sw_go;
         TRG_PIN:   go = rise[0];
         TRG_TIMER: go = rise[1];
         TRG_PWM:   go = rise[2];
         default:   go = 1'b0;
      endcase
   end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
   import adc_seq_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic [DW-1:0] value,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  cmp_mode_e     mode,
   output logic          hit
);
   logic below, above;
   assign below = value < lo;
   assign above = value > hi;

   always_comb begin
      unique case (mode)
         CMP_BELOW:   hit = below;
         CMP_ABOVE:   hit = above;
         CMP_INSIDE:  hit = !below && !above;
         CMP_OUTSIDE: hit = below || above;
         default:     hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH = 16,
   parameter int DW  = 12,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_stb,
   input  logic [CH_W-1:0]         st_ch,
   input  logic [DW-1:0]           st_val,
   input  logic                    rd_stb,
   input  logic [CH_W-1:0]         rd_ch,
   input  logic                    ovr_clr,
   output logic [NCH-1:0][DW-1:0]  res,
   output logic [NCH-1:0]          eoc,
   output logic [NCH-1:0]          ovr
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [DW-1:0] val_q;
      logic          eoc_q, ovr_q;
      logic          hit_st, hit_rd;

      assign hit_st = st_stb && (st_ch == CH_W'(i));
      assign hit_rd = rd_stb && (rd_ch == CH_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= '0;
            eoc_q <= 1'b0;
            ovr_q <= 1'b0;
         end else begin
            if (hit_st)      val_q <= st_val;
            if (hit_st)      eoc_q <= 1'b1;
            else if (hit_rd) eoc_q <= 1'b0;
            if (hit_st && eoc_q && !hit_rd) ovr_q <= 1'b1;
            else if (ovr_clr)               ovr_q <= 1'b0;
         end
      end

      assign res[i] = val_q;
      assign eoc[i] = eoc_q;
      assign ovr[i] = ovr_q;
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int DW          = 12,
   parameter int SU_W        = 8,
   parameter int TRK_W       = 4,
   parameter int SYNC_STAGES = 0,
   localparam int CH_W  = $clog2(NCH),
   localparam int CNT_W = (SU_W > TRK_W) ? SU_W : TRK_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [5:0]      wr_addr,
   input  logic [31:0]     wr_data,
   input  logic            rd_en,
   input  logic [5:0]      rd_addr,
   output logic [31:0]     rd_data,
   input  logic            ext_trig,
   input  logic            tmr_trig,
   input  logic            pwm_trig,
   output logic [CH_W-1:0] mux_sel,
   output logic            core_pwr,
   output logic            conv_start,
   input  logic            conv_done,
   input  logic [DW-1:0]   conv_data,
   output logic            busy,
   output logic            drdy,
   output logic            fault
);
   if (NCH < 2 || NCH > 32) begin : g_bad_nch
      $error("adc_seq_ctrl: NCH must be within 2..32");
   end
   if (DW < 10 || DW > 16) begin : g_bad_dw
      $error("adc_seq_ctrl: DW must be within 10..16");
   end
   if (SU_W < 1 || SU_W > 8 || TRK_W < 1 || TRK_W > 4) begin : g_bad_cnt
      $error("adc_seq_ctrl: SU_W must be 1..8 and TRK_W 1..4");
   end

   // configuration
   trig_src_e        src_q;
   logic             lowres_q, sleep_q, call_q;
   logic [SU_W-1:0]  su_q;
   logic [TRK_W-1:0] trk_q;
   logic [NCH-1:0]   chen_q;
   cmp_mode_e        cmode_q;
   logic [CH_W-1:0]  cch_q;
   logic [DW-1:0]    lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= TRG_SOFT; lowres_q <= 1'b0; sleep_q <= 1'b0;
         su_q <= '0; trk_q <= '0; chen_q <= '0;
         cmode_q <= CMP_BELOW; call_q <= 1'b0; cch_q <= '0;
         lo_q <= '0; hi_q <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            A_MODE: begin
               src_q    <= trig_src_e'(wr_data[1:0]);
               lowres_q <= wr_data[2];
               sleep_q  <= wr_data[3];
               su_q     <= wr_data[4 +: SU_W];
               trk_q    <= wr_data[12 +: TRK_W];
            end
            A_CHEN:   chen_q <= wr_data[NCH-1:0];
            A_CMPCFG: begin
               cmode_q <= cmp_mode_e'(wr_data[1:0]);
               call_q  <= wr_data[2];
               cch_q   <= wr_data[8 +: CH_W];
            end
            A_THR: begin
               lo_q <= wr_data[0 +: DW];
               hi_q <= wr_data[16 +: DW];
            end
            default: ;
         endcase
      end
   end

   // trigger
   logic sw_go, go;
   assign sw_go = wr_en && (wr_addr == A_CTRL) && wr_data[0];

   adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
      .clk(clk), .rst_n(rst_n), .src(src_q), .sw_go(sw_go),
      .ext_in(ext_trig), .tmr_in(tmr_trig), .pwm_in(pwm_trig), .go(go)
   );

   // sequencer
   seq_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CH_W-1:0] ch_q;
   logic [5:0]      first_s, next_s;
   logic            store;

   assign first_s = scan_up(32'(chen_q), 6'd0);
   assign next_s  = scan_up(32'(chen_q), 6'(ch_q) + 6'd1);
   assign store   = (st_q == ST_WAIT) && conv_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cnt_q <= '0; ch_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (go && first_s[5]) begin
               ch_q <= first_s[CH_W-1:0];
               if (sleep_q) begin st_q <= ST_WAKE;  cnt_q <= CNT_W'(su_q);  end
               else         begin st_q <= ST_TRACK; cnt_q <= CNT_W'(trk_q); end
            end
            ST_WAKE: begin
               if (cnt_q == '0) begin st_q <= ST_TRACK; cnt_q <= CNT_W'(trk_q); end
               else cnt_q <= cnt_q - 1'b1;
            end
            ST_TRACK: begin
               if (cnt_q == '0) st_q <= ST_START;
               else cnt_q <= cnt_q - 1'b1;
            end
            ST_START: st_q <= ST_WAIT;
            ST_WAIT: if (conv_done) begin
               if (next_s[5]) begin
                  ch_q <= next_s[CH_W-1:0]; st_q <= ST_TRACK; cnt_q <= CNT_W'(trk_q);
               end else st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign conv_start = (st_q == ST_START);
   assign mux_sel    = ch_q;
   assign core_pwr   = !sleep_q || busy;

   // result capture
   logic [DW-1:0] cval;
   assign cval = lowres_q ? (conv_data >> (DW - 10)) : conv_data;

   logic [5:0]  rd_idx;
   logic        rd_ch_hit;
   logic [NCH-1:0][DW-1:0] res;
   logic [NCH-1:0] eoc, ovr;

   assign rd_idx    = rd_addr - A_CHBASE;
   assign rd_ch_hit = (rd_addr >= A_CHBASE) && (rd_idx < 6'(NCH));

   adc_result_bank #(.NCH(NCH), .DW(DW)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .st_stb(store), .st_ch(ch_q), .st_val(cval),
      .rd_stb(rd_en && rd_ch_hit), .rd_ch(rd_idx[CH_W-1:0]),
      .ovr_clr(rd_en && (rd_addr == A_OVR)),
      .res(res), .eoc(eoc), .ovr(ovr)
   );

   // window compare
   logic hit, cmp_q;
   adc_window_cmp #(.DW(DW)) cmp_i (
      .value(cval), .lo(lo_q), .hi(hi_q), .mode(cmode_q), .hit(hit)
   );

   logic [DW-1:0]   last_q;
   logic [CH_W-1:0] last_ch_q;
   logic            drdy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= '0; last_ch_q <= '0; drdy_q <= 1'b0; cmp_q <= 1'b0;
      end else begin
         drdy_q <= store;
         if (store) begin
            last_q    <= cval;
            last_ch_q <= ch_q;
         end
         if (store && hit && (call_q || (cch_q == ch_q))) cmp_q <= 1'b1;
         else if (rd_en && (rd_addr == A_CMPST))          cmp_q <= 1'b0;
      end
   end

   assign drdy  = drdy_q;
   assign fault = cmp_q;

   // read mux
   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_MODE: begin
            rd_data[1:0]          = src_q;
            rd_data[2]            = lowres_q;
            rd_data[3]            = sleep_q;
            rd_data[4 +: SU_W]    = su_q;
            rd_data[12 +: TRK_W]  = trk_q;
         end
         A_CHEN:  rd_data[NCH-1:0] = chen_q;
         A_LAST: begin
            rd_data[DW-1:0]     = last_q;
            rd_data[16 +: CH_W] = last_ch_q;
         end
         A_EOC:   rd_data[NCH-1:0] = eoc;
         A_OVR:   rd_data[NCH-1:0] = ovr;
         A_CMPST: rd_data[0]       = cmp_q;
         default: if (rd_ch_hit) rd_data[DW-1:0] = res[rd_idx[CH_W-1:0]];
      endcase
   end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_en,
   input logic [5:0]      rd_addr,
   input logic [CH_W-1:0] mux_sel,
   input logic            core_pwr,
   input logic            conv_start,
   input logic            conv_done,
   input logic            busy,
   input logic            drdy,
   input logic            fault
);
   // R6
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R6
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(conv_start) |-> $stable(mux_sel));

   // R13
   drdy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |-> $past(conv_done));

   // R13
   drdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |=> !drdy);

   // R10
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault) |-> $past(rd_en && (rd_addr == A_CMPST)));

   // R10
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(conv_done));

   // R7
   pwr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> core_pwr);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
   .mux_sel(mux_sel), .core_pwr(core_pwr), .conv_start(conv_start),
   .conv_done(conv_done), .busy(busy), .drdy(drdy), .fault(fault)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
   import adc_seq_pkg::*;

   localparam int NCH = 16;
   localparam int DW  = 12;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic        ext_trig = 1'b0, tmr_trig = 1'b0, pwm_trig = 1'b0;
   logic [3:0]  mux_sel;
   logic        core_pwr, conv_start, busy, drdy, fault;
   logic        conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;

   always #4 clk = ~clk;

   adc_seq_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_trig(ext_trig), .tmr_trig(tmr_trig), .pwm_trig(pwm_trig),
      .mux_sel(mux_sel), .core_pwr(core_pwr), .conv_start(conv_start),
      .conv_done(conv_done), .conv_data(conv_data),
      .busy(busy), .drdy(drdy), .fault(fault)
   );

   int n_tot = 0, n_bad = 0;
   bit finished = 0;
   logic [DW-1:0] model_val [NCH];
   logic [3:0] conv_log [256];
   int n_log = 0;
   int n_drdy = 0;

   // converter core model
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            conv_log[n_log % 256] = mux_sel;
            n_log++;
            repeat (LAT) @(negedge clk);
            conv_data = model_val[mux_sel];
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   always @(negedge clk) if (drdy) n_drdy++;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         1: ext_trig = 1'b1;
         2: tmr_trig = 1'b1;
         default: pwm_trig = 1'b1;
      endcase
      @(negedge clk);
      ext_trig = 1'b0; tmr_trig = 1'b0; pwm_trig = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int ch, input int seed);
      return DW'((ch * 263 + seed * 57 + 5) & 12'hFFF);
   endfunction

   function automatic bit win_exp(input int mode, input int v, input int lo, input int hi);
      case (mode)
         0: return v < lo;
         1: return v > hi;
         2: return (v >= lo) && (v <= hi);
         default: return (v < lo) || (v > hi);
      endcase
   endfunction

   // software-triggered pass with full checks on order, data and strobes
   task automatic run_seq(input logic [15:0] mask, input int seed);
      int base, dbase, cnt, k;
      logic [31:0] d;
      for (int c = 0; c < NCH; c++) model_val[c] = pat(c, seed);
      wr(A_CHEN, {16'h0, mask});
      base = n_log; dbase = n_drdy; cnt = $countones(mask);
      wr(A_CTRL, 32'h1);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(n_log - base == cnt, "R1 conversion count", n_log - base, cnt);
      chk(n_drdy - dbase == cnt, "R13 drdy count", n_drdy - dbase, cnt);
      k = 0;
      for (int c = 0; c < NCH; c++) begin
         if (mask[c]) begin
            chk(conv_log[(base + k) % 256] == 4'(c), "R1 ascending order",
                conv_log[(base + k) % 256], c);
            k++;
         end
      end
      if (cnt > 0) begin
         rd(A_EOC, d);
         chk(d[15:0] == mask, "R11 eoc vector", d[15:0], mask);
         for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
               rd(A_CHBASE + 6'(c), d);
               chk(d == 32'(pat(c, seed)), "R5 channel register", d, pat(c, seed));
            end
         end
         rd(A_EOC, d);
         chk(d[15:0] == 16'h0, "R11 eoc cleared by reads", d[15:0], 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tot++; n_bad++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n, last_c;
      for (int c = 0; c < NCH; c++) model_val[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(busy == 0, "R1 reset busy", busy, 0);
      chk(fault == 0, "R10 reset fault", fault, 0);
      chk(core_pwr == 1, "R7 reset core_pwr", core_pwr, 1);
      chk(conv_start == 0, "R6 reset conv_start", conv_start, 0);
      rd(A_EOC, d);
      chk(d == 0, "R11 reset eoc", d, 0);

      // R1 R5 R11 R13 mask sweep
      run_seq(16'h0001, 1);
      run_seq(16'h8000, 2);
      run_seq(16'hA5A5, 3);
      run_seq(16'hFFFF, 4);
      run_seq(16'h0000, 5);
      chk(busy == 0, "R1 empty mask stays idle", busy, 0);

      // R5 last-result register holds final channel
      run_seq(16'h0410, 6);
      rd(A_LAST, d);
      chk(d[11:0] == pat(10, 6), "R5 last value", d[11:0], pat(10, 6));
      chk(d[19:16] == 4'd10, "R5 last channel", d[19:16], 10);

      // R4 10-bit mode
      wr(A_MODE, 32'h4);
      wr(A_CHEN, 32'h0008);
      model_val[3] = 12'hABC;
      wr(A_CTRL, 32'h1); wait_idle();
      rd(A_CHBASE + 6'd3, d);
      chk(d == 32'h2AF, "R4 low resolution channel", d, 32'h2AF);
      rd(A_LAST, d);
      chk(d[11:0] == 12'h2AF, "R4 low resolution last", d[11:0], 12'h2AF);
      wr(A_MODE, 32'h0);
      wr(A_CTRL, 32'h1); wait_idle();
      rd(A_CHBASE + 6'd3, d);
      chk(d == 32'hABC, "R4 full resolution", d, 32'hABC);

      // R6 R7 timing sweep
      for (int sl = 0; sl < 2; sl++) begin
         for (int t = 0; t < 16; t += 5) begin
            for (int s = 0; s < 7; s += 6) begin
               int exp_n;
               wr(A_MODE, 32'((t << 12) | (s << 4) | (sl << 3)));
               if (sl == 1) chk(core_pwr == 0, "R7 idle power down", core_pwr, 0);
               wr(A_CTRL, 32'h1);
               n = 0;
               while (!conv_start && n < 400) begin @(posedge clk); @(negedge clk); n++; end
               exp_n = (sl == 1) ? (s + t + 2) : (t + 1);
               chk(n == exp_n, (sl == 1) ? "R7 wake+track delay" : "R6 track delay", n, exp_n);
               wait_idle();
            end
         end
      end
      wr(A_MODE, 32'h0);
      rd(A_OVR, d);

      // R2 trigger source selection
      wr(A_CHEN, 32'h1);
      for (int s = 1; s < 4; s++) begin
         wr(A_MODE, 32'(s));
         wr(A_CTRL, 32'h1);
         repeat (2) @(negedge clk);
         chk(busy == 0, "R2 soft start ignored", busy, 0);
         for (int o = 1; o < 4; o++) begin
            if (o != s) begin
               pulse(o);
               @(negedge clk);
               chk(busy == 0, "R2 other source ignored", busy, 0);
            end
         end
         pulse(s);
         chk(busy == 1, "R2 selected source starts", busy, 1);
         wait_idle();
      end
      wr(A_MODE, 32'h0);

      // R3 trigger during pass ignored
      wr(A_MODE, 32'h3000);
      wr(A_CHEN, 32'h000F);
      n = n_log;
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h1);
      wait_idle();
      repeat (3) @(negedge clk);
      chk(n_log - n == 4, "R3 retrigger ignored", n_log - n, 4);
      chk(busy == 0, "R3 idle after pass", busy, 0);
      wr(A_MODE, 32'h0);

      // R12 overrun
      rd(A_OVR, d);
      for (int c = 0; c < NCH; c++) begin rd(A_CHBASE + 6'(c), d); end
      wr(A_CHEN, 32'h0004);
      wr(A_CTRL, 32'h1); wait_idle();
      rd(A_OVR, d);
      chk(d == 0, "R12 no overrun first store", d, 0);
      wr(A_CTRL, 32'h1); wait_idle();
      rd(A_OVR, d);
      chk(d == 32'h4, "R12 overrun set", d, 32'h4);
      rd(A_OVR, d);
      chk(d == 0, "R12 overrun cleared by read", d, 0);
      rd(A_CHBASE + 6'd2, d);
      wr(A_CTRL, 32'h1); wait_idle();
      rd(A_OVR, d);
      chk(d == 0, "R12 no overrun after read", d, 0);

      // R8 R10 compare sweep, single channel 3
      wr(A_THR, {4'h0, 12'hC00, 4'h0, 12'h400});
      wr(A_CHEN, 32'h0008);
      for (int m = 0; m < 4; m++) begin
         wr(A_CMPCFG, 32'((3 << 8) | m));
         for (int k = 0; k < 5; k++) begin
            int v;
            bit e;
            case (k)
               0: v = 'h100; 1: v = 'h400; 2: v = 'h800; 3: v = 'hC00; default: v = 'hF00;
            endcase
            e = win_exp(m, v, 'h400, 'hC00);
            model_val[3] = DW'(v);
            wr(A_CTRL, 32'h1); wait_idle();
            repeat (3) @(negedge clk);
            chk(fault == e, "R8 window mode result", fault, e);
            rd(A_CMPST, d);
            chk(d[0] == e, "R10 status flag", d[0], e);
            chk(fault == 0, "R10 fault cleared by read", fault, 0);
         end
      end

      // R9 channel selection
      model_val[3] = 12'h100;
      wr(A_CMPCFG, 32'((5 << 8) | 0));
      wr(A_CTRL, 32'h1); wait_idle();
      chk(fault == 0, "R9 other channel not compared", fault, 0);
      wr(A_CMPCFG, 32'((5 << 8) | 4 | 0));
      wr(A_CTRL, 32'h1); wait_idle();
      chk(fault == 1, "R9 all channels compared", fault, 1);
      repeat (4) @(negedge clk);
      chk(fault == 1, "R10 fault sticky", fault, 1);
      rd(A_CMPST, d);
      chk(fault == 0, "R10 fault cleared", fault, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end
endmodule